// File: doc/BRIEF.md
# Combinational BCD-to-Binary Converter

This block turns a packed four-digit decimal value into its plain binary equivalent. Each decimal digit takes four bits. The thousands digit sits in the top nibble and the units digit in the bottom nibble. The converter has no clock, no storage and no handshake. The binary result follows the input through combinational logic only.

The conversion uses the right-shift, subtract-three method, laid out in space as a chain of rows. Every row shifts the combined decimal/binary field one place towards the binary end. The row then repairs each decimal digit whose top bit became set, using a small correction cell. The cell adds 1101 (minus three) and drops the carry.

Rows and cells that can never act on a legal input are left out. For four digits this leaves 21 cells in ten rows, and at most ten cells lie in series on any path. Inputs holding a digit above nine are outside the contract, and the output for them is undefined.

Top module: `bcd2bin_array`

## Requirements
- R1: For every input whose four nibbles are each 0 to 9, `bin_o` equals 1000·bcd_i[15:12] + 100·bcd_i[11:8] + 10·bcd_i[7:4] + bcd_i[3:0].
- R2: For every legal input, `bin_o` is at most 9999, and all state bits above the 14 result bits are zero after the last row.
- R3: A correction cell whose input digit has its most significant bit set outputs the digit minus three. Inputs 8 to 15 give 5 to 12.
- R4: A correction cell whose input digit has its most significant bit clear outputs the digit unchanged. Inputs 0 to 7 give 0 to 7.
- R5: The output responds to an input change within the same clock period, with no clock edge involved.
- R6: `bin_o[0]` always equals `bcd_i[0]`.
- R7: A single non-zero digit d placed in nibble position p (p=0 for bits 3:0, up to p=3 for bits 15:12), with all other nibbles zero, gives d·10^p.
- R8: The range end points convert exactly: an all-zero input gives 0, and the input 16'h9999 gives 9999.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bcd_i | input | 16 | Packed decimal value, four digits, thousands in the top nibble |
| bin_o | output | 14 | Binary value of `bcd_i` |

## Verification
Bound checkers test three things whenever their inputs change. The first is the numeric result of every legal input. The second is the zero state above the result field and the pass-through of the lowest bit. The third is the subtract-three or pass rule inside every one of the 21 cells.

Some behaviour only the bench's directed scenarios can show. One is that all 10000 legal codes are actually reached. Another is digit placement by nibble position. A third is the full truth table of an isolated cell. The last is that the output settles between clock edges without any edge.

// File: rtl/bcd2bin_pkg.sv
`timescale 1ns/1ps
package bcd2bin_pkg;

  localparam int DIGIT_W = 4;

  // 10 raised to n, for constant sizing
  function automatic int pow10(input int n);
    int r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  // number of shift rows that still contain a live correction
  function automatic int row_count(input int digits);
    int k;
    k = 0;
    while (((pow10(digits) - 1) >> k) >= 10) k++;
    return k;
  endfunction

  // width of the largest legal result
  function automatic int bin_width(input int digits);
    return $clog2(pow10(digits));
  endfunction

  // a cell is needed on digit pos in row step only when the digit above
  // it can still be non-zero before that row's shift
  function automatic bit cell_used(input int digits, input int pos, input int step);
    return ((pow10(digits) - 1) >> (step - 1)) >= pow10(pos + 1);
  endfunction

endpackage

// File: rtl/bcd_fix_cell.sv
`timescale 1ns/1ps
module bcd_fix_cell #(
  parameter int W = 4
) (
  input  logic [W-1:0] digit_i,
  output logic [W-1:0] digit_o
);

  // minus three in W-bit two's complement (1101 for W=4)
  localparam logic [W-1:0] MINUS3 = W'((1 << W) - 3);

  logic [W-1:0] addend;
  logic [W-1:0] sum;

  always_comb begin
    addend = digit_i[W-1] ? MINUS3 : '0;
    sum    = digit_i + addend;   // carry out falls off the top
  end

  assign digit_o = sum;

endmodule

// File: rtl/bcd2bin_row.sv
`timescale 1ns/1ps
module bcd2bin_row import bcd2bin_pkg::*; #(
  parameter  int DIGITS = 4,
  parameter  int STEP   = 1,
  localparam int IN_W   = DIGITS * DIGIT_W + STEP - 1,
  localparam int OUT_W  = IN_W + 1
) (
  input  logic [IN_W-1:0]  st_i,
  output logic [OUT_W-1:0] st_o
);

  // Shifting the field right by one keeps every bit index and moves the
  // decimal/binary boundary up by one: a zero enters at the top.
  logic [OUT_W-1:0] shifted;
  assign shifted = {1'b0, st_i};

  // binary part below the boundary passes straight through
  assign st_o[STEP-1:0] = shifted[STEP-1:0];

  for (genvar j = 0; j < DIGITS; j++) begin : g_dig
    localparam int LO = STEP + j * DIGIT_W;
    if (cell_used(DIGITS, j, STEP)) begin : g_fix
      bcd_fix_cell #(.W(DIGIT_W)) u_cell (
        .digit_i (shifted[LO +: DIGIT_W]),
        .digit_o (st_o[LO +: DIGIT_W])
      );
    end else begin : g_pass
      assign st_o[LO +: DIGIT_W] = shifted[LO +: DIGIT_W];
    end
  end

endmodule

// File: rtl/bcd2bin_array.sv
`timescale 1ns/1ps
module bcd2bin_array import bcd2bin_pkg::*; #(
  parameter  int DIGITS = 4,
  localparam int BCD_W  = DIGITS * DIGIT_W,
  localparam int ROWS   = row_count(DIGITS),
  localparam int BIN_W  = bin_width(DIGITS),
  localparam int ST_W   = BCD_W + ROWS
) (
  input  logic [BCD_W-1:0] bcd_i,
  output logic [BIN_W-1:0] bin_o
);

  logic [ST_W-1:0] final_st;

  for (genvar k = 1; k <= ROWS; k++) begin : g_row
    logic [BCD_W+k-1:0] st;
    if (k == 1) begin : g_first
      bcd2bin_row #(.DIGITS(DIGITS), .STEP(k)) u_row (
        .st_i (bcd_i),
        .st_o (st)
      );
    end else begin : g_next
      bcd2bin_row #(.DIGITS(DIGITS), .STEP(k)) u_row (
        .st_i (g_row[k-1].st),
        .st_o (st)
      );
    end
  end

  assign final_st = g_row[ROWS].st;

  // after the last row only the lowest digit can be non-zero; it joins
  // the binary bits to form the result
  assign bin_o = final_st[BIN_W-1:0];

endmodule

// File: rtl/bcd2bin_chk.sv
`timescale 1ns/1ps
module bcd2bin_chk import bcd2bin_pkg::*; #(
  parameter  int DIGITS = 4,
  localparam int BCD_W  = DIGITS * DIGIT_W,
  localparam int BIN_W  = bin_width(DIGITS),
  localparam int HI_W   = BCD_W + row_count(DIGITS) - BIN_W
) (
  input logic [BCD_W-1:0] bcd_i,
  input logic [BIN_W-1:0] bin_o,
  input logic [HI_W-1:0]  hi_i
);

  function automatic bit legal(input logic [BCD_W-1:0] v);
    for (int j = 0; j < DIGITS; j++)
      if (v[j*DIGIT_W +: DIGIT_W] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int weigh(input logic [BCD_W-1:0] v);
    int s;
    s = 0;
    for (int j = DIGITS - 1; j >= 0; j--)
      s = s * 10 + int'(v[j*DIGIT_W +: DIGIT_W]);
    return s;
  endfunction

  always_comb begin
    // R1
    value_match_chk: assert (!legal(bcd_i) || int'(bin_o) == weigh(bcd_i))
      else $error("value mismatch");
    // R2
    upper_zero_chk: assert (!legal(bcd_i) || hi_i == '0)
      else $error("state above result not zero");
    // R2
    range_top_chk: assert (!legal(bcd_i) || int'(bin_o) < pow10(DIGITS))
      else $error("result above range");
    // R6
    lsb_pass_chk: assert (bin_o[0] == bcd_i[0])
      else $error("lowest bit changed");
  end

endmodule

bind bcd2bin_array bcd2bin_chk #(.DIGITS(DIGITS)) u_chk (
  .bcd_i (bcd_i),
  .bin_o (bin_o),
  .hi_i  (final_st[ST_W-1:BIN_W])
);

// File: rtl/bcd_fix_chk.sv
`timescale 1ns/1ps
module bcd_fix_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] digit_i,
  input logic [W-1:0] digit_o
);

  always_comb begin
    // R3
    cell_sub_chk: assert (!digit_i[W-1] || int'(digit_o) == int'(digit_i) - 3)
      else $error("cell did not subtract three");
    // R4
    cell_pass_chk: assert (digit_i[W-1] || digit_o == digit_i)
      else $error("cell altered a small digit");
    // R3
    cell_span_chk: assert (!digit_i[W-1] ||
                           (int'(digit_o) >= (1 << (W-1)) - 3 && int'(digit_o) <= (1 << W) - 4))
      else $error("cell output out of span");
  end

endmodule

bind bcd_fix_cell bcd_fix_chk #(.W(W)) u_fchk (
  .digit_i (digit_i),
  .digit_o (digit_o)
);

// File: tb/sim_bcd2bin_array.sv
`timescale 1ns/1ps
module sim_bcd2bin_array;

  logic        clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [15:0] bcd;
  logic [13:0] bin;
  logic [3:0]  c_in;
  logic [3:0]  c_out;

  bcd2bin_array u0 (
    .bcd_i (bcd),
    .bin_o (bin)
  );

  bcd_fix_cell #(.W(4)) u_cell (
    .digit_i (c_in),
    .digit_o (c_out)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  function automatic logic [15:0] to_bcd(input int n);
    return {4'(n / 1000), 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] v);
    @(posedge clk);
    bcd = v;
    @(negedge clk);
  endtask

  task automatic t_idle;
    apply(16'h0000);
    check(bin == 14'd0, "R8 zero input", int'(bin), 0);
  endtask

  task automatic t_cell_table;
    for (int v = 0; v < 16; v++) begin
      c_in = 4'(v);
      #1;
      if (v >= 8) check(int'(c_out) == v - 3, "R3 cell subtract", int'(c_out), v - 3);
      else        check(int'(c_out) == v,     "R4 cell pass",     int'(c_out), v);
    end
  endtask

  task automatic t_sweep;
    for (int n = 0; n < 10000; n++) begin
      apply(to_bcd(n));
      check(int'(bin) == n, "R1 value", int'(bin), n);
      check(int'(bin) <= 9999, "R2 range", int'(bin), 9999);
      check(bin[0] == bcd[0], "R6 lsb", int'(bin[0]), int'(bcd[0]));
    end
  endtask

  task automatic t_positions;
    for (int p = 0; p < 4; p++) begin
      for (int d = 1; d < 10; d++) begin
        int w;
        w = d;
        for (int i = 0; i < p; i++) w = w * 10;
        apply(16'(d << (4 * p)));
        check(int'(bin) == w, "R7 digit weight", int'(bin), w);
      end
    end
  endtask

  task automatic t_extremes;
    apply(16'h9999);
    check(int'(bin) == 9999, "R8 top value", int'(bin), 9999);
    check(bin[13:0] == 14'h270F, "R2 upper bits", int'(bin), 9999);
    apply(16'h0000);
    check(int'(bin) == 0, "R8 zero value", int'(bin), 0);
  endtask

  task automatic t_no_edge;
    @(negedge clk);
    bcd = 16'h1234;
    #1;
    check(int'(bin) == 1234, "R5 settle without edge", int'(bin), 1234);
    bcd = 16'h0567;
    #1;
    check(int'(bin) == 567, "R5 second change", int'(bin), 567);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bcd  = 16'h0000;
    c_in = 4'h0;
    t_idle();
    t_cell_table();
    t_positions();
    t_extremes();
    t_no_edge();
    t_sweep();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule